// File: doc/BRIEF.md
# Receive Frame Acceptance and Block Packer

This block sits behind the preamble stripper of an Ethernet receive path. It takes the frame one byte per valid cycle and gathers the bytes into 16-byte blocks, which it hands to the receive buffer as 128-bit words. A frame whose length is not a multiple of the block size ends in a block padded with zero bytes. That last block carries a flag and the true frame length, so the padding can be removed further on.

While it packs, the block tracks where it is in the frame. Once the destination field has fully arrived, it raises a one-cycle request to an external address matcher. The matcher can answer with a reject at any time before the frame is accepted. The frame counts as accepted only after a full 64-byte collision window has arrived with no reject.

A reject drops the rest of the frame. A frame that ends inside the window is flagged as short. A frame that runs past the configured maximum length is cut off and flagged as an overflow. The byte counter and the block lane restart with every new frame.

Top module: `rx_accept_packer`

## Requirements
- R1: `addrCheck` is high for exactly one cycle, in the cycle after the sixth byte of a frame is taken.
- R2: `accepted` pulses for one cycle, in the cycle after the 64th byte is taken, provided `addrReject` was not seen while the frame was open, including in the cycle of that byte. It pulses at most once per frame. A reject that arrives after acceptance is ignored: no `rejected` pulse, and all of the frame's blocks are still delivered.
- R3: Frame byte n is placed in lane n mod 16, which is bits [8*lane+7 : 8*lane] of `outData`. `outValid` is high for one cycle, in the cycle after the byte that fills lane 15 or ends the frame. `outCount` on every block gives the number of frame bytes received so far, and every block that is not last is full.
- R4: The final block of a frame has `outLast` set. Its lanes at and above (length mod 16) are zero when the length is not a multiple of 16, and its `outCount` equals the true frame length.
- R5: An `addrReject` seen while a frame is open and not yet accepted gives a one-cycle `rejected` pulse in the next cycle. The byte taken in that cycle and every later byte up to the frame end produce no block. No `accepted` or `shortFrame` pulse follows for that frame.
- R6: A frame that ends with fewer than 64 bytes and no reject gives a one-cycle `shortFrame` pulse together with its last block, and no `accepted` pulse.
- R7: A byte that arrives after `MAX_LEN` bytes of the same frame gives a one-cycle `overflow` pulse in the next cycle. The frame produces no further blocks, and none of its blocks carries `outLast`.
- R8: After a frame ends, whether it was delivered, short, rejected or overflowed, the next frame starts at lane 0 with a count of 1. Bytes left in a partly filled block of a dropped frame never appear in a later block.
- R9: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A frame byte is present on `inData` |
| inData | input | 8 | Frame byte |
| inEnd | input | 1 | Qualified by `inValid`: this byte is the last one of the frame |
| addrReject | input | 1 | Reject from the external address matcher |
| addrCheck | output | 1 | One-cycle request: destination field complete |
| accepted | output | 1 | One-cycle pulse: frame passed the collision window |
| rejected | output | 1 | One-cycle pulse: frame dropped by address reject |
| shortFrame | output | 1 | One-cycle pulse: frame ended inside the collision window |
| overflow | output | 1 | One-cycle pulse: frame exceeded `MAX_LEN` |
| outValid | output | 1 | A packed block is present |
| outData | output | BLK_BYTES*8 | Packed block, lane 0 in the low byte |
| outLast | output | 1 | Block is the final block of the frame |
| outCount | output | clog2(MAX_LEN+1) | Frame bytes received up to and including this block |

## Verification
A wrong lane index or byte count shows up at the ports in the next emitted block. The block appears a cycle early or late, bytes land in shifted lanes, or `outCount` departs from the running total. It also shows up in the timing of `addrCheck` and `accepted`, which are scored against the exact cycle of the sixth and sixty-fourth bytes. A buffer that is not cleared after a drop stays hidden until the next frame's first block, so each dropped frame in the bench is followed at once by a short clean frame whose lanes are compared byte for byte. A frame state left open after a drop would show as a missing or extra pulse in the following frame.

// File: rtl/rx_accept_pkg.sv
package rx_accept_pkg;

  // Strobes from the frame control to the packing datapath.
  typedef struct packed {
    logic wr;    // store inData in the current lane
    logic clr;   // discard the partly filled block
    logic emit;  // hand the block (with this byte) downstream
    logic last;  // the emitted block ends the frame
  } pack_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // between frames, next byte opens one
    ST_OPEN = 2'd1,  // frame in progress
    ST_DROP = 2'd2   // rejected or overflowed, wait for the end marker
  } frame_state_t;

endpackage

// File: rtl/rx_accept_ctrl.sv
module rx_accept_ctrl
  import rx_accept_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  parameter int CHECK_AT  = 6,
  parameter int ACC_LEN   = 64,
  parameter int MAX_LEN   = 1536,
  parameter int LANEW     = $clog2(BLK_BYTES),
  parameter int CNTW      = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inEnd,
  input  logic             addrReject,
  output pack_strobe_t     stb,
  output logic [LANEW-1:0] lane,
  output logic [CNTW-1:0]  count,
  output logic             addrCheck,
  output logic             accepted,
  output logic             rejected,
  output logic             shortFrame,
  output logic             overflow
);

  frame_state_t    state, stateNext;
  logic [CNTW-1:0] cnt, curCnt, cntN;
  logic            accDone;
  logic            canTake, rejNow, ovfNow, take, endNow;

  always_comb begin
    canTake = (state != ST_DROP);
    curCnt  = (state == ST_IDLE) ? '0 : cnt;
    cntN    = curCnt + CNTW'(1);
    rejNow  = addrReject && (state == ST_OPEN) && !accDone;
    ovfNow  = inValid && canTake && !rejNow && (curCnt == CNTW'(MAX_LEN));
    take    = inValid && canTake && !rejNow && !ovfNow;
    endNow  = inValid && inEnd;

    stb.wr   = take;
    stb.clr  = rejNow || ovfNow;
    stb.emit = take && ((curCnt[LANEW-1:0] == LANEW'(BLK_BYTES - 1)) || inEnd);
    stb.last = take && inEnd;
    lane     = curCnt[LANEW-1:0];
    count    = cntN;

    if (endNow)                stateNext = ST_IDLE;
    else if (rejNow || ovfNow) stateNext = ST_DROP;
    else if (take)             stateNext = ST_OPEN;
    else                       stateNext = state;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      accDone    <= 1'b0;
      addrCheck  <= 1'b0;
      accepted   <= 1'b0;
      rejected   <= 1'b0;
      shortFrame <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      state <= stateNext;
      if (take) cnt <= cntN;
      if (endNow)                                  accDone <= 1'b0;
      else if (take && cntN == CNTW'(ACC_LEN))     accDone <= 1'b1;
      addrCheck  <= take && (cntN == CNTW'(CHECK_AT));
      accepted   <= take && (cntN == CNTW'(ACC_LEN));
      rejected   <= rejNow;
      shortFrame <= take && inEnd && (cntN < CNTW'(ACC_LEN));
      overflow   <= ovfNow;
    end
  end

endmodule

// File: rtl/rx_accept_dp.sv
module rx_accept_dp
  import rx_accept_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  parameter int LANEW     = $clog2(BLK_BYTES),
  parameter int CNTW      = 11,
  parameter int DW        = BLK_BYTES * 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inData,
  input  pack_strobe_t     stb,
  input  logic [LANEW-1:0] lane,
  input  logic [CNTW-1:0]  count,
  output logic             outValid,
  output logic [DW-1:0]    outData,
  output logic             outLast,
  output logic [CNTW-1:0]  outCount
);

  logic [BLK_BYTES-1:0][7:0] fill, fillNext;

  always_comb begin
    fillNext = fill;
    if (stb.wr) fillNext[lane] = inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fill     <= '0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outData  <= '0;
      outCount <= '0;
    end else begin
      // Unused lanes stay zero, which doubles as the padding of a short block.
      if (stb.clr || stb.emit) fill <= '0;
      else                     fill <= fillNext;
      outValid <= stb.emit;
      outLast  <= stb.last;
      if (stb.emit) begin
        outData  <= fillNext;
        outCount <= count;
      end
    end
  end

endmodule

// File: rtl/rx_accept_packer.sv
module rx_accept_packer
  import rx_accept_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  parameter int CHECK_AT  = 6,
  parameter int ACC_LEN   = 64,
  parameter int MAX_LEN   = 1536,
  localparam int LANEW    = $clog2(BLK_BYTES),
  localparam int CNTW     = $clog2(MAX_LEN + 1),
  localparam int DW       = BLK_BYTES * 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [7:0]      inData,
  input  logic            inEnd,
  input  logic            addrReject,
  output logic            addrCheck,
  output logic            accepted,
  output logic            rejected,
  output logic            shortFrame,
  output logic            overflow,
  output logic            outValid,
  output logic [DW-1:0]   outData,
  output logic            outLast,
  output logic [CNTW-1:0] outCount
);

  pack_strobe_t     stb;
  logic [LANEW-1:0] lane;
  logic [CNTW-1:0]  count;

  rx_accept_ctrl #(
    .BLK_BYTES(BLK_BYTES), .CHECK_AT(CHECK_AT), .ACC_LEN(ACC_LEN),
    .MAX_LEN(MAX_LEN), .LANEW(LANEW), .CNTW(CNTW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inEnd(inEnd),
    .addrReject(addrReject), .stb(stb), .lane(lane), .count(count),
    .addrCheck(addrCheck), .accepted(accepted), .rejected(rejected),
    .shortFrame(shortFrame), .overflow(overflow)
  );

  rx_accept_dp #(
    .BLK_BYTES(BLK_BYTES), .LANEW(LANEW), .CNTW(CNTW), .DW(DW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .stb(stb), .lane(lane),
    .count(count), .outValid(outValid), .outData(outData),
    .outLast(outLast), .outCount(outCount)
  );

endmodule

// File: rtl/rx_accept_chk.sv
module rx_accept_chk #(
  parameter int BLK_BYTES = 16,
  parameter int ACC_LEN   = 64,
  parameter int MAX_LEN   = 1536,
  localparam int LANEW    = $clog2(BLK_BYTES),
  localparam int CNTW     = $clog2(MAX_LEN + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   addrCheck,
  input logic                   accepted,
  input logic                   rejected,
  input logic                   shortFrame,
  input logic                   overflow,
  input logic                   outValid,
  input logic [BLK_BYTES*8-1:0] outData,
  input logic                   outLast,
  input logic [CNTW-1:0]        outCount
);

  p_check_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    addrCheck |=> !addrCheck);

  p_accept_alone_r2: assert property (@(posedge clk) disable iff (!rstN)
    accepted |-> !rejected && !shortFrame && !overflow);

  p_count_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outCount != '0) && (outCount <= CNTW'(MAX_LEN)));

  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |-> (outCount[LANEW-1:0] == '0));

  p_last_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  for (genvar k = 0; k < BLK_BYTES; k++) begin : g_pad
    p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && outLast && (outCount[LANEW-1:0] != '0)
       && (outCount[LANEW-1:0] <= LANEW'(k)))
      |-> (outData[8*k +: 8] == 8'h00));
  end

  p_reject_no_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    rejected |-> !outValid && !accepted);

  p_short_with_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    shortFrame |-> outValid && outLast && (outCount < CNTW'(ACC_LEN)));

  p_no_overflow_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !outValid);

endmodule

bind rx_accept_packer rx_accept_chk #(
  .BLK_BYTES(BLK_BYTES), .ACC_LEN(ACC_LEN), .MAX_LEN(MAX_LEN)
) u_chk (
  .clk(clk), .rstN(rstN), .addrCheck(addrCheck), .accepted(accepted),
  .rejected(rejected), .shortFrame(shortFrame), .overflow(overflow),
  .outValid(outValid), .outData(outData), .outLast(outLast),
  .outCount(outCount)
);

// File: tb/sim_rx_accept_packer.sv
module sim_rx_accept_packer;
  localparam int BB = 16;
  localparam int ML = 128;
  localparam int CW = $clog2(ML + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0, inEnd = 1'b0, addrReject = 1'b0;
  logic [7:0]    inData = 8'h00;
  logic          addrCheck, accepted, rejected, shortFrame, overflow;
  logic          outValid, outLast;
  logic [BB*8-1:0] outData;
  logic [CW-1:0] outCount;

  always #10 clk = ~clk;

  rx_accept_packer #(.BLK_BYTES(BB), .CHECK_AT(6), .ACC_LEN(64), .MAX_LEN(ML)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inEnd(inEnd),
    .addrReject(addrReject), .addrCheck(addrCheck), .accepted(accepted),
    .rejected(rejected), .shortFrame(shortFrame), .overflow(overflow),
    .outValid(outValid), .outData(outData), .outLast(outLast), .outCount(outCount)
  );

  int checks = 0, errors = 0, stepN = 0;
  logic [BB*8-1:0] rData [0:15];
  logic            rLast [0:15];
  int              rCount[0:15];
  int nBlk, nChk, nAcc, nRej, nShort, nOvf;
  int sChk, sAcc, sRej, sShort, sOvf;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearRec();
    nBlk = 0; nChk = 0; nAcc = 0; nRej = 0; nShort = 0; nOvf = 0;
    sChk = -1; sAcc = -1; sRej = -1; sShort = -1; sOvf = -1;
  endtask

  // One clock: drive at the falling edge, sample after the next falling edge.
  task automatic step(input logic v, input logic [7:0] d, input logic e, input logic r);
    inValid = v; inData = d; inEnd = e; addrReject = r;
    @(posedge clk); @(negedge clk);
    stepN++;
    if (outValid) begin
      if (nBlk < 16) begin
        rData[nBlk] = outData; rLast[nBlk] = outLast; rCount[nBlk] = int'(outCount);
      end
      nBlk++;
    end
    if (addrCheck)  begin nChk++;   sChk = stepN;   end
    if (accepted)   begin nAcc++;   sAcc = stepN;   end
    if (rejected)   begin nRej++;   sRej = stepN;   end
    if (shortFrame) begin nShort++; sShort = stepN; end
    if (overflow)   begin nOvf++;   sOvf = stepN;   end
    inValid = 1'b0; inEnd = 1'b0; addrReject = 1'b0;
  endtask

  task automatic sendFrame(input int len, input logic [7:0] base, input int rejAt,
                           output int startS);
    startS = stepN + 1;
    for (int i = 0; i < len; i++)
      step(1'b1, 8'(int'(base) + i), i == len - 1, i == rejAt);
    step(1'b0, 8'h00, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic verifyClean(input int len, input logic [7:0] base, input string tag);
    int nb = (len + BB - 1) / BB;
    chk(nBlk == nb, {tag, " R3"}, "block count", nBlk, nb);
    for (int k = 0; k < nb && k < 16; k++) begin
      int expCnt = (BB * (k + 1) < len) ? BB * (k + 1) : len;
      chk(rCount[k] == expCnt, {tag, " R3"}, "outCount", rCount[k], expCnt);
      chk(rLast[k] == (k == nb - 1), {tag, " R4"}, "outLast", int'(rLast[k]), int'(k == nb - 1));
      for (int j = 0; j < BB; j++) begin
        int idx = BB * k + j;
        int act = int'(rData[k][8*j +: 8]);
        int exp = (idx < len) ? ((int'(base) + idx) & 255) : 0;
        chk(act == exp, (idx < len) ? {tag, " R3"} : {tag, " R4"}, "lane byte", act, exp);
      end
    end
  endtask

  task automatic testReset();
    chk({addrCheck, accepted, rejected, shortFrame, overflow, outValid, outLast} == 7'b0,
        "R9", "flags in reset", 1, 0);
    chk(outData == '0 && outCount == '0, "R9", "data/count in reset", 1, 0);
  endtask

  task automatic testLong();
    int s;
    clearRec(); sendFrame(100, 8'h10, -1, s);
    verifyClean(100, 8'h10, "long");
    chk(nChk == 1, "R1", "addrCheck pulses", nChk, 1);
    chk(sChk == s + 5, "R1", "addrCheck step", sChk - s, 5);
    chk(nAcc == 1, "R2", "accepted pulses", nAcc, 1);
    chk(sAcc == s + 63, "R2", "accepted step", sAcc - s, 63);
    chk(nShort == 0 && nRej == 0, "R6", "no short/reject", nShort + nRej, 0);
  endtask

  task automatic testShort();
    int s;
    clearRec(); sendFrame(20, 8'hA0, -1, s);
    verifyClean(20, 8'hA0, "short");
    chk(nShort == 1 && sShort == s + 19, "R6", "shortFrame step", sShort - s, 19);
    chk(nAcc == 0, "R6", "no accept on short", nAcc, 0);
    chk(nChk == 1 && sChk == s + 5, "R1", "addrCheck on short", sChk - s, 5);
  endtask

  task automatic testExact();
    int s;
    clearRec(); sendFrame(64, 8'h33, -1, s);
    verifyClean(64, 8'h33, "exact64");
    chk(nAcc == 1 && sAcc == s + 63, "R2", "accept at 64", sAcc - s, 63);
    chk(nShort == 0, "R6", "64 bytes not short", nShort, 0);
  endtask

  task automatic testReject();
    int s;
    clearRec(); sendFrame(80, 8'h40, 29, s);
    chk(nRej == 1 && sRej == s + 29, "R5", "rejected step", sRej - s, 29);
    chk(nBlk == 1, "R5", "blocks before reject only", nBlk, 1);
    chk(nBlk >= 1 && rLast[0] == 1'b0, "R5", "no last block", int'(rLast[0]), 0);
    chk(nAcc == 0 && nShort == 0, "R5", "no accept/short", nAcc + nShort, 0);
    clearRec(); sendFrame(18, 8'h80, -1, s);
    verifyClean(18, 8'h80, "R8 after-reject");
    chk(nChk == 1 && sChk == s + 5, "R8", "addrCheck after reject", sChk - s, 5);
  endtask

  task automatic testLateReject();
    int s;
    clearRec(); sendFrame(80, 8'h55, 70, s);
    chk(nRej == 0, "R2", "late reject ignored", nRej, 0);
    chk(nAcc == 1, "R2", "still accepted", nAcc, 1);
    verifyClean(80, 8'h55, "R2 late-reject");
  endtask

  task automatic testOverflow();
    int s;
    int lastCnt;
    clearRec(); sendFrame(140, 8'h01, -1, s);
    chk(nOvf == 1 && sOvf == s + ML, "R7", "overflow step", sOvf - s, ML);
    chk(nBlk == ML / BB, "R7", "blocks up to limit", nBlk, ML / BB);
    for (int k = 0; k < nBlk && k < 16; k++)
      chk(rLast[k] == 1'b0, "R7", "no last on overflow", int'(rLast[k]), 0);
    lastCnt = (nBlk >= 1 && nBlk <= 16) ? rCount[nBlk-1] : -1;
    chk(lastCnt == ML, "R7", "final count", lastCnt, ML);
    chk(nAcc == 1, "R2", "accepted before overflow", nAcc, 1);
    clearRec(); sendFrame(5, 8'hC0, -1, s);
    verifyClean(5, 8'hC0, "R8 after-overflow");
    chk(nOvf == 0, "R8", "no overflow next frame", nOvf, 0);
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testLong();
    testShort();
    testExact();
    testReject();
    testLateReject();
    testOverflow();
    finish();
  end

endmodule